// File: doc/BRIEF.md
# Edge-Aligned Data Clock Recovery

This block rebuilds a slow bit clock from a received serial data line. A fast reference arrives as a one-cycle enable pulse (`ref_tick`) on the system clock. A modulo-`DIV` phase counter advances on each pulse. The synchronized data level is compared with the level held at the previous pulse. A mismatch is a transition, and it reloads the counter to its mid-bit value. This keeps the recovered clock locked to the edges of the incoming data instead of running free.

The data line first passes through a flip-flop synchronizer. A retiming register then samples it once per bit, at the point half a bit after the last edge. The block drives three outputs: the recovered clock, the retimed data and a one-cycle transition strobe. With no edges on the line, the counter keeps its last phase and goes on counting.

Top module: `dclk_recover`

## Requirements
- R1: A synchronous active-high `rst` clears the synchronizer, the held data level, the phase counter and all three outputs. In the cycle after a clock edge with `rst` high, `rec_clk`, `ret_data` and `edge_stb` are 0.
- R2: `ser_in` passes through a two-stage synchronizer. A change on `ser_in` sampled at clock edge n can first count as a transition at a `ref_tick` edge n+2.
- R3: `edge_stb` is 1 for exactly the cycle after a clock edge where `ref_tick` is 1 and the synchronized level differs from the level stored at the previous `ref_tick` edge. Otherwise it is 0.
- R4: At a clock edge with `ref_tick` low, `rec_clk` and `ret_data` keep their values.
- R5: At a `ref_tick` edge with no transition, the phase counter steps up by one and wraps from `DIV`-1 to 0. With no transitions, `rec_clk` is therefore periodic with `DIV` ticks.
- R6: At a `ref_tick` edge with a transition, the counter loads `DIV`/2. So `rec_clk` rises on the `DIV`/2-th tick after the edge.
- R7: After each `ref_tick` edge, `rec_clk` is 1 exactly when the new counter value is below `DIV`/2.
- R8: At a `ref_tick` edge with the counter at `DIV`-1 and no transition, `ret_data` takes the synchronized level. At every other edge it holds.
- R9: When a transition and the counter value `DIV`-1 meet at the same tick, the reload wins and `ret_data` is not updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 1 | One-cycle enable pulse at the reference rate |
| ser_in | input | 1 | Received serial data, asynchronous |
| rec_clk | output | 1 | Recovered bit clock, rising at the mid-bit sample point |
| ret_data | output | 1 | Data retimed to the recovered clock |
| edge_stb | output | 1 | One-cycle pulse per detected data transition |

## Verification
The bench aims at a transition that lands on the sampling tick. A design that let sampling win there would latch the new bit half a bit early, and `ret_data` would disagree. It also runs long gaps with no edges. A counter that stalled or reset during a gap would stretch or shift `rec_clk` away from the `DIV`-tick period. Edges arrive both with ticks on every cycle and with ticks spaced apart, and the synchronizer depth is exercised as well. A missing synchronizer stage shows up as a strobe one tick early. Updating the held level between ticks shows up as lost or duplicated strobes.

// File: rtl/dclk_pkg.sv
package dclk_pkg;

    // Per-cycle event handed from the edge detector to the phase counter.
    typedef struct packed {
        logic tick;   // reference pulse this cycle
        logic trans;  // synchronized level differs from the one held at the last tick
        logic level;  // synchronized data level
    } edge_evt_t;

endpackage

// File: rtl/dclk_sync.sv
module dclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                st_d = st_q;
                st_d.chain = din;
            end
        end else begin : g_chain
            always_comb begin
                st_d = st_q;
                st_d.chain = {st_q.chain[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout = st_q.chain[STAGES-1];

endmodule

// File: rtl/dclk_edge.sv
module dclk_edge
    import dclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      level,
    output edge_evt_t evt,
    output logic      strobe
);

    typedef struct packed {
        logic prev;    // level captured at the last tick
        logic strobe;  // registered transition pulse
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        evt.tick  = tick;
        evt.level = level;
        evt.trans = tick & (level ^ st_q.prev);

        st_d        = st_q;
        st_d.strobe = evt.trans;
        if (tick) st_d.prev = level;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign strobe = st_q.strobe;

endmodule

// File: rtl/dclk_phase.sv
module dclk_phase
    import dclk_pkg::*;
#(
    parameter  int DIV  = 8,
    localparam int CW   = $clog2(DIV),
    localparam int HALF = DIV / 2,
    localparam int LAST = DIV - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  edge_evt_t     evt,
    output logic          rec_clk,
    output logic          ret_data,
    output logic [CW-1:0] cnt
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rec;
        logic          data;
    } phase_st_t;

    phase_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (evt.tick) begin
            if (evt.trans) begin
                st_d.cnt = CW'(HALF);
            end else begin
                if (st_q.cnt == CW'(LAST)) st_d.cnt = '0;
                else                       st_d.cnt = st_q.cnt + CW'(1);
                if (st_q.cnt == CW'(LAST)) st_d.data = evt.level;
            end
            st_d.rec = (st_d.cnt < CW'(HALF));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rec_clk  = st_q.rec;
    assign ret_data = st_q.data;
    assign cnt      = st_q.cnt;

endmodule

// File: rtl/dclk_recover.sv
module dclk_recover
    import dclk_pkg::*;
#(
    parameter  int DIV         = 8,
    parameter  int SYNC_STAGES = 2,
    localparam int CW          = $clog2(DIV)
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_tick,
    input  logic ser_in,
    output logic rec_clk,
    output logic ret_data,
    output logic edge_stb
);

    logic          level_s;
    edge_evt_t     evt;
    logic [CW-1:0] phase_cnt;

    dclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (ser_in),
        .dout (level_s)
    );

    dclk_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .tick   (ref_tick),
        .level  (level_s),
        .evt    (evt),
        .strobe (edge_stb)
    );

    dclk_phase #(.DIV(DIV)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .rec_clk  (rec_clk),
        .ret_data (ret_data),
        .cnt      (phase_cnt)
    );

endmodule

// File: rtl/dclk_recover_chk.sv
module dclk_recover_chk #(
    parameter  int DIV  = 8,
    localparam int CW   = $clog2(DIV),
    localparam int HALF = DIV / 2,
    localparam int LAST = DIV - 1
) (
    input logic          clk,
    input logic          rst,
    input logic          ref_tick,
    input logic          rec_clk,
    input logic          ret_data,
    input logic          edge_stb,
    input logic [CW-1:0] cnt
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!rec_clk && !ret_data && !edge_stb)); // R1

    AST_STROBE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        edge_stb |-> $past(ref_tick)); // R3

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        !ref_tick |=> ($stable(rec_clk) && $stable(ret_data))); // R4

    AST_FREE_RUN_STEP: assert property (@(posedge clk) disable iff (rst)
        ($past(ref_tick) && !$past(rst) && !edge_stb) |->
        (cnt == (($past(cnt) == CW'(LAST)) ? CW'(0) : $past(cnt) + CW'(1)))); // R5

    AST_EDGE_RELOAD: assert property (@(posedge clk) disable iff (rst)
        edge_stb |-> (cnt == CW'(HALF))); // R6

    AST_REC_LEVEL: assert property (@(posedge clk) disable iff (rst)
        ($past(ref_tick) && !$past(rst)) |-> (rec_clk == (cnt < CW'(HALF)))); // R7

endmodule

bind dclk_recover dclk_recover_chk #(.DIV(DIV)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ref_tick (ref_tick),
    .rec_clk  (rec_clk),
    .ret_data (ret_data),
    .edge_stb (edge_stb),
    .cnt      (phase_cnt)
);

// File: tb/tb_dclk_recover.sv
`timescale 1ns/1ps
module tb_dclk_recover;

    localparam int DIV  = 8;
    localparam int HALF = DIV / 2;
    localparam int LAST = DIV - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_tick = 1'b0;
    logic ser_in = 1'b0;
    logic rec_clk, ret_data, edge_stb;

    always #2 clk = ~clk;  // 250 MHz

    dclk_recover #(.DIV(DIV), .SYNC_STAGES(2)) dut (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .ser_in   (ser_in),
        .rec_clk  (rec_clk),
        .ret_data (ret_data),
        .edge_stb (edge_stb)
    );

    typedef struct {
        logic  rec;
        logic  data;
        logic  stb;
        string tag;
    } exp_t;

    exp_t  exp_q[$];
    int    checks = 0;
    int    errors = 0;
    string cur = "R1";

    // Behavioural model of the requirements
    logic m_s1 = 0, m_s2 = 0, m_prev = 0, m_rec = 0, m_data = 0, m_stb = 0;
    int   m_cnt = 0;

    task automatic model(input logic r, input logic d, input logic t);
        logic o_s2, tr;
        o_s2 = m_s2;
        if (r) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_rec = 0; m_data = 0; m_stb = 0; m_cnt = 0;
        end else begin
            m_s2  = m_s1;
            m_s1  = d;
            m_stb = 0;
            if (t) begin
                tr     = (o_s2 != m_prev);
                m_prev = o_s2;
                if (!tr && m_cnt == LAST) m_data = o_s2;
                m_cnt  = tr ? HALF : ((m_cnt == LAST) ? 0 : m_cnt + 1);
                m_rec  = (m_cnt < HALF);
                m_stb  = tr;
            end
        end
    endtask

    // Driver: drives inputs for the next edge and pushes the expected result
    task automatic step(input logic r, input logic d, input logic t);
        exp_t e;
        @(negedge clk);
        rst = r; ser_in = d; ref_tick = t;
        model(r, d, t);
        e.rec = m_rec; e.data = m_data; e.stb = m_stb; e.tag = cur;
        exp_q.push_back(e);
    endtask

    task automatic cmp(input string req, input string ctx, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) at %0t: actual=%0b expected=%0b", req, ctx, $time, act, exp);
        end
    endtask

    // Monitor: pops and compares after each edge
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            cmp("R3 edge_stb",  e.tag, edge_stb, e.stb);
            cmp("R7 rec_clk",   e.tag, rec_clk,  e.rec);
            cmp("R8 ret_data",  e.tag, ret_data, e.data);
        end
    end

    task automatic run_tests();
        logic d;
        // R1: reset state
        cur = "R1 reset";
        repeat (3) step(1, 1, 1);
        // R2: synchronizer latency, ticks every cycle
        cur = "R2 sync depth";
        d = 0;
        repeat (10) step(0, d, 1);
        d = 1;
        repeat (6) step(0, d, 1);
        // R4: data moves but no ticks
        cur = "R4 hold between ticks";
        for (int i = 0; i < 8; i++) begin d = ~d; step(0, d, 0); end
        // R5: free run with sparse ticks and steady data
        cur = "R5 free run";
        for (int i = 0; i < 40; i++) begin step(0, d, 1); step(0, d, 0); end
        // R6: single edge then ticks every third cycle
        cur = "R6 reload";
        d = ~d;
        for (int i = 0; i < 30; i++) begin step(0, d, 1); step(0, d, 0); step(0, d, 0); end
        // R9: transition landing on the sampling tick
        cur = "R9 reload beats sample";
        for (int k = 0; k < 3; k++) begin
            int guard;
            guard = 0;
            while (m_cnt != LAST - 2 && guard < 4 * DIV) begin step(0, d, 1); guard++; end
            d = ~d;
            repeat (2) step(0, d, 1);
            checks++;
            if (m_cnt != LAST) begin
                errors++;
                $display("FAIL R9 setup: actual=%0d expected=%0d", m_cnt, LAST);
            end
            step(0, d, 1);
            repeat (DIV) step(0, d, 1);
        end
        // Mixed random traffic
        cur = "R3/R7/R8 mixed";
        for (int i = 0; i < 600; i++) begin
            if (($urandom % 12) == 0) d = ~d;
            step(0, d, ($urandom % 3) != 0);
        end
        // R1 again mid-stream
        cur = "R1 reset mid-run";
        step(1, d, 1);
        step(0, d, 0);
        repeat (4) step(0, d, 1);
    endtask

    initial begin
        fork
            begin
                run_tests();
                @(negedge clk);
                @(negedge clk);
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL all watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule